// File: doc/BRIEF.md
# Transmit Cell Buffer with Idle-Cell Fill

This block sits on the transmit side, between the ATM-layer write port and a downstream cell processor that consumes whole cells. The ATM layer writes a cell one unit per cycle. A unit is a byte on an 8-bit bus or a word on a 16-bit bus. The buffer stores up to a software-selected number of cells. A cell becomes visible to the reader only once its final unit has arrived.

The reader pulls one unit per cycle. At every cell boundary the block decides between the oldest complete user cell and a generated idle cell. It picks the idle cell whenever nothing complete is stored.

A two-register microprocessor port reports the buffer state and holds the configuration. The configuration covers bus width, cell length, buffer depth, PHY mode and handshake mode. Changing the width, length or depth empties the buffer, so that stored units are never reinterpreted under a new layout.

Top module: `utx_cell_fifo`

## Requirements
- R1: After reset the status register (address 0x71) reads 0x03, the configuration register (address 0x6A) reads 0x00, `single_phy` is 0, `ovr_sticky` is 0, and the reader presents an idle cell start (`rd_sop`=1, `rd_idle`=1).
- R2: Configuration bits are: [5] handshake mode, [4] single-PHY select, [3] 52-byte cells, [2:1] depth code, [0] 16-bit bus. Bits 5:0 read back as written. Bits 7:6 read 0. `single_phy` follows bit 4 and `handshake_mode` follows bit 5. Any other address reads 0.
- R3: A cell has 53 units in 8-bit/53-byte mode, 52 units in 8-bit/52-byte mode, 27 words in 16-bit/53-byte mode and 26 words in 16-bit/52-byte mode. A partly written cell is never served: the reader gets an idle cell until the last unit is written.
- R4: The depth code 00/01/10/11 sets a capacity of 2/4/8/16 cells. Status bit 1 reads 0 exactly when that many complete cells are stored, and 1 otherwise.
- R5: A write that would start a new cell while the buffer is full is dropped. It sets `ovr_sticky`, which stays 1 until a flush. The stored cells are delivered unchanged.
- R6: Status bit 0 reads 1 when no complete or partial cell is held, and 0 otherwise. Status bits 7:2 read 0.
- R7: Idle cell bytes are: bytes 0-2 = 0x00, byte 3 = 0x01, then in 53-byte mode byte 4 = 0x52, and all remaining payload bytes = 0x6A. In 16-bit mode each word carries byte 2i in bits 15:8 and byte 2i+1 in bits 7:0. The 53rd byte is padded with 0x00 in the low half of word 26.
- R8: User cells are delivered whole, in write order, unit by unit. In 8-bit mode `rd_data` carries the written low byte with bits 15:8 zero. In 16-bit mode it carries the full written word.
- R9: A configuration write that changes bits 3:0 flushes the buffer: it becomes empty and `ovr_sticky` clears. A write that leaves bits 3:0 unchanged keeps the contents.
- R10: `rd_sop` is 1 on the first unit of every cell, user or idle, and 0 on the others. `rd_idle` is 1 for every unit of an idle cell and 0 for every unit of a user cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| wr_en | input | 1 | ATM-layer unit write strobe |
| wr_data | input | 16 | ATM-layer unit data (low byte in 8-bit mode) |
| rd_req | input | 1 | Reader consumes the presented unit |
| rd_data | output | 16 | Presented unit |
| rd_sop | output | 1 | Presented unit is the first of a cell |
| rd_idle | output | 1 | Presented unit belongs to an idle cell |
| ovr_sticky | output | 1 | A write was dropped because the buffer was full |
| single_phy | output | 1 | Single-PHY mode selected |
| handshake_mode | output | 1 | Handshake mode bit |

## Verification
A wrong cell count would show in the status register on the next read: a full flag at the wrong fill level, or an empty flag with a cell pending. It would also make the reader start an idle cell when a user cell is waiting, or the reverse, at the very next cell boundary. A wrong write or read position shows as shifted or wrong units inside the first cell read back, at most one cell length later. A missed flush leaves stale data that appears on the first read after a configuration change. Overrun handling is checked in two ways: the sticky flag must persist across reads, and every stored cell must survive a dropped write intact.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int UNITS_MAX = 53;
  localparam int UNIT_W    = 16;
  localparam int MAX_CELLS = 16;
  localparam int CNT_W     = $clog2(MAX_CELLS + 1);
  localparam int PTR_W     = $clog2(MAX_CELLS);
  localparam int POS_W     = $clog2(UNITS_MAX + 1);
  localparam int IDX_W     = $clog2(MAX_CELLS * UNITS_MAX);

  typedef struct packed {
    logic       handshake;
    logic       single_phy;
    logic       cell52;
    logic [1:0] depth;
    logic       wide;
  } utx_cfg_t;

  // units per cell for a given bus width and cell length
  function automatic logic [POS_W-1:0] cell_units(input logic wide, input logic cell52);
    logic [POS_W-1:0] nbytes;
    nbytes = cell52 ? POS_W'(52) : POS_W'(53);
    return wide ? ((nbytes + POS_W'(1)) >> 1) : nbytes;
  endfunction

  // cell capacity selected by the depth code
  function automatic logic [CNT_W-1:0] cap_cells(input logic [1:0] code);
    return CNT_W'(2) << code;
  endfunction

  // one byte of the generated idle cell
  function automatic logic [7:0] idle_byte(input logic [6:0] idx, input logic cell52);
    logic [6:0] nbytes;
    nbytes = cell52 ? 7'd52 : 7'd53;
    if (idx >= nbytes)           return 8'h00;
    else if (idx < 7'd3)         return 8'h00;
    else if (idx == 7'd3)        return 8'h01;
    else if (idx == 7'd4 && !cell52) return 8'h52;
    else                         return 8'h6A;
  endfunction

  // one unit of the idle cell at unit position pos
  function automatic logic [UNIT_W-1:0] idle_unit(input logic [POS_W-1:0] pos,
                                                  input logic wide, input logic cell52);
    if (wide)
      return {idle_byte({pos, 1'b0}, cell52), idle_byte({pos, 1'b1}, cell52)};
    else
      return {8'h00, idle_byte({1'b0, pos}, cell52)};
  endfunction
endpackage

// File: rtl/utx_cfg_regs.sv
module utx_cfg_regs
  import utx_pkg::*;
#(
  parameter logic [7:0] STATUS_ADDR = 8'h71,
  parameter logic [7:0] CONFIG_ADDR = 8'h6A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       buf_full,
  input  logic       buf_empty,
  output logic [7:0] reg_rdata,
  output utx_cfg_t   cfg,
  output logic       flush
);
  utx_cfg_t cfg_q;
  logic     cfg_hit;
  logic     unused_wdata;

  assign unused_wdata = &{1'b0, reg_wdata[7:6]};
  assign cfg_hit = reg_wr && (reg_addr == CONFIG_ADDR);
  // layout fields occupy bits 3:0; a change there empties the buffer
  assign flush   = cfg_hit && (reg_wdata[3:0] != cfg_q[3:0]);
  assign cfg     = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (cfg_hit) cfg_q <= utx_cfg_t'(reg_wdata[5:0]);
  end

  always_comb begin
    if (reg_addr == STATUS_ADDR)      reg_rdata = {6'b0, ~buf_full, buf_empty};
    else if (reg_addr == CONFIG_ADDR) reg_rdata = {2'b0, cfg_q};
    else                              reg_rdata = 8'h00;
  end

  // R9
  flush_only_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cfg_q[3:0] != $past(cfg_q[3:0])));
endmodule

// File: rtl/utx_cell_mem.sv
module utx_cell_mem
  import utx_pkg::*;
#(
  parameter int ENTRIES = MAX_CELLS * UNITS_MAX,
  parameter int W       = UNIT_W,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdata;
  end

  assign rdata = store[ridx];
endmodule

// File: rtl/utx_write_ctl.sv
module utx_write_ctl
  import utx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [POS_W-1:0] units,
  input  logic [CNT_W-1:0] cap,
  input  logic [CNT_W-1:0] cells_used,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_idx,
  output logic             commit,
  output logic             drop,
  output logic             wr_busy,
  output logic             ovr
);
  localparam logic [IDX_W-1:0] UM = IDX_W'(UNITS_MAX);

  logic [PTR_W-1:0] wr_ptr;
  logic [POS_W-1:0] wr_pos;
  logic             at_last;
  logic             full_now;

  assign full_now = (cells_used >= cap);
  assign at_last  = (wr_pos == units - POS_W'(1));
  // a new cell can only start with a free slot; a started cell always finishes
  assign drop     = wr_en && (wr_pos == '0) && full_now;
  assign mem_we   = wr_en && !drop && !flush;
  assign commit   = mem_we && at_last;
  assign wr_busy  = (wr_pos != '0);
  assign mem_idx  = IDX_W'(wr_ptr) * UM + IDX_W'(wr_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      wr_pos <= '0;
      ovr    <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      wr_pos <= '0;
      ovr    <= 1'b0;
    end else begin
      if (drop) ovr <= 1'b1;
      if (mem_we) begin
        if (at_last) begin
          wr_pos <= '0;
          wr_ptr <= (CNT_W'(wr_ptr) == cap - CNT_W'(1)) ? '0 : wr_ptr + PTR_W'(1);
        end else begin
          wr_pos <= wr_pos + POS_W'(1);
        end
      end
    end
  end

  // R3
  commit_ends_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !wr_busy);
  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !flush) |=> ovr);
  // R5
  drop_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !wr_busy && ovr);
endmodule

// File: rtl/utx_read_ctl.sv
module utx_read_ctl
  import utx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              rd_req,
  input  logic              wide,
  input  logic              cell52,
  input  logic [POS_W-1:0]  units,
  input  logic [CNT_W-1:0]  cap,
  input  logic [CNT_W-1:0]  cells_used,
  input  logic [UNIT_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [UNIT_W-1:0] rd_data,
  output logic              rd_sop,
  output logic              rd_idle,
  output logic              done_user
);
  localparam logic [IDX_W-1:0] UM = IDX_W'(UNITS_MAX);

  logic [PTR_W-1:0] rd_ptr;
  logic [POS_W-1:0] rd_pos;
  logic             src_idle_q;
  logic             at_last;

  assign rd_sop    = (rd_pos == '0);
  // the source is chosen at the cell boundary and held for the whole cell
  assign rd_idle   = rd_sop ? (cells_used == '0) : src_idle_q;
  assign at_last   = (rd_pos == units - POS_W'(1));
  assign done_user = rd_req && at_last && !rd_idle && !flush;
  assign mem_idx   = IDX_W'(rd_ptr) * UM + IDX_W'(rd_pos);

  always_comb begin
    if (rd_idle)   rd_data = idle_unit(rd_pos, wide, cell52);
    else if (wide) rd_data = mem_rdata;
    else           rd_data = {8'h00, mem_rdata[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      rd_pos     <= '0;
      src_idle_q <= 1'b1;
    end else if (flush) begin
      rd_ptr     <= '0;
      rd_pos     <= '0;
      src_idle_q <= 1'b1;
    end else if (rd_req) begin
      if (rd_sop) src_idle_q <= rd_idle;
      if (at_last) begin
        rd_pos <= '0;
        if (!rd_idle)
          rd_ptr <= (CNT_W'(rd_ptr) == cap - CNT_W'(1)) ? '0 : rd_ptr + PTR_W'(1);
      end else begin
        rd_pos <= rd_pos + POS_W'(1);
      end
    end
  end

  // R10
  src_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !at_last && !flush) |=> (rd_idle == $past(rd_idle)) && !rd_sop);
endmodule

// File: rtl/utx_cell_fifo.sv
module utx_cell_fifo
  import utx_pkg::*;
#(
  parameter logic [7:0] STATUS_ADDR = 8'h71,
  parameter logic [7:0] CONFIG_ADDR = 8'h6A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        rd_req,
  output logic [15:0] rd_data,
  output logic        rd_sop,
  output logic        rd_idle,
  output logic        ovr_sticky,
  output logic        single_phy,
  output logic        handshake_mode
);
  utx_cfg_t         cfg;
  logic             flush;
  logic [POS_W-1:0] units;
  logic [CNT_W-1:0] cap;
  logic [CNT_W-1:0] cells_used;
  logic             buf_full, buf_empty;
  logic             mem_we, commit, drop, wr_busy, done_user;
  logic [IDX_W-1:0] widx, ridx;
  logic [UNIT_W-1:0] mem_rdata;

  assign units          = cell_units(cfg.wide, cfg.cell52);
  assign cap            = cap_cells(cfg.depth);
  assign buf_full       = (cells_used == cap);
  assign buf_empty      = (cells_used == '0) && !wr_busy;
  assign single_phy     = cfg.single_phy;
  assign handshake_mode = cfg.handshake;

  utx_cfg_regs #(.STATUS_ADDR(STATUS_ADDR), .CONFIG_ADDR(CONFIG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .buf_full(buf_full), .buf_empty(buf_empty),
    .reg_rdata(reg_rdata), .cfg(cfg), .flush(flush));

  utx_write_ctl u_wr (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .units(units),
    .cap(cap), .cells_used(cells_used), .mem_we(mem_we), .mem_idx(widx),
    .commit(commit), .drop(drop), .wr_busy(wr_busy), .ovr(ovr_sticky));

  utx_cell_mem #(.ENTRIES(MAX_CELLS * UNITS_MAX), .W(UNIT_W)) u_mem (
    .clk(clk), .we(mem_we), .widx(widx), .wdata(wr_data),
    .ridx(ridx), .rdata(mem_rdata));

  utx_read_ctl u_rd (
    .clk(clk), .rst_n(rst_n), .flush(flush), .rd_req(rd_req),
    .wide(cfg.wide), .cell52(cfg.cell52), .units(units), .cap(cap),
    .cells_used(cells_used), .mem_rdata(mem_rdata), .mem_idx(ridx),
    .rd_data(rd_data), .rd_sop(rd_sop), .rd_idle(rd_idle),
    .done_user(done_user));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cells_used <= '0;
    else if (flush) cells_used <= '0;
    else begin
      case ({commit, done_user})
        2'b10:   cells_used <= cells_used + CNT_W'(1);
        2'b01:   cells_used <= cells_used - CNT_W'(1);
        default: cells_used <= cells_used;
      endcase
    end
  end

  // R4
  used_le_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cells_used <= cap);
  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cells_used == '0) && !ovr_sticky && rd_sop);
  // R3
  idle_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sop && cells_used == '0) |-> rd_idle);
  // R8
  user_done_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_user |-> (cells_used != '0));
  // R5
  drop_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> buf_full);
endmodule

// File: tb/utx_cell_fifo_test.sv
module utx_cell_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic        rd_req = 1'b0;
  logic [15:0] rd_data;
  logic        rd_sop, rd_idle, ovr_sticky, single_phy, handshake_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the configuration and contents
  bit          m_w16, m_c52;
  int          m_depth;
  logic [7:0]  m_cfg = 8'h00;
  logic [15:0] q[$];
  int          m_cells;

  always #4 clk = ~clk;

  utx_cell_fifo uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_en(wr_en),
    .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data), .rd_sop(rd_sop),
    .rd_idle(rd_idle), .ovr_sticky(ovr_sticky), .single_phy(single_phy),
    .handshake_mode(handshake_mode));

  function automatic int b_units();
    case ({m_w16, m_c52})
      2'b00: return 53;
      2'b01: return 52;
      2'b10: return 27;
      default: return 26;
    endcase
  endfunction

  function automatic int b_cap();
    case (m_depth)
      0: return 2;
      1: return 4;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [7:0] b_idle_byte(int i);
    int last;
    last = m_c52 ? 51 : 52;
    if (i > last) return 8'h00;
    case (i)
      0, 1, 2: return 8'h00;
      3:       return 8'h01;
      4:       return m_c52 ? 8'h6A : 8'h52;
      default: return 8'h6A;
    endcase
  endfunction

  function automatic logic [15:0] b_idle_unit(int p);
    if (m_w16) return {b_idle_byte(2 * p), b_idle_byte(2 * p + 1)};
    return {8'h00, b_idle_byte(p)};
  endfunction

  function automatic logic [7:0] b_status();
    return {6'b0, (m_cells == b_cap()) ? 1'b0 : 1'b1, (m_cells == 0) ? 1'b1 : 1'b0};
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_cfg(logic [7:0] v);
    if (v[3:0] != m_cfg[3:0]) begin
      q.delete();
      m_cells = 0;
    end
    m_cfg = v;
    m_w16 = v[0]; m_depth = int'(v[2:1]); m_c52 = v[3];
    reg_write(8'h6A, v);
  endtask

  task automatic put_unit(logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic read_unit(string req, logic [15:0] exp_d, bit exp_sop, bit exp_idle);
    @(negedge clk);
    chk(req, "rd_data", rd_data, exp_d);
    chk("R10", "rd_sop", {15'b0, rd_sop}, {15'b0, exp_sop});
    chk("R10", "rd_idle", {15'b0, rd_idle}, {15'b0, exp_idle});
    rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic write_cell(int nunits);
    for (int u = 0; u < nunits; u++) begin
      logic [15:0] d;
      d = 16'($urandom);
      put_unit(d);
      q.push_back(m_w16 ? d : {8'h00, d[7:0]});
    end
    m_cells++;
  endtask

  task automatic read_user_cell();
    int n;
    n = b_units();
    for (int u = 0; u < n; u++) begin
      logic [15:0] e;
      e = q.pop_front();
      read_unit("R8", e, u == 0, 1'b0);
    end
    m_cells--;
  endtask

  task automatic read_idle_cell(string req);
    int n;
    n = b_units();
    for (int u = 0; u < n; u++) read_unit(req, b_idle_unit(u), u == 0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'h5eed_7245));
    m_w16 = 0; m_c52 = 0; m_depth = 0; m_cells = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    reg_read(8'h71, r); chk("R1", "status", {8'h0, r}, 16'h0003);
    reg_read(8'h6A, r); chk("R1", "config", {8'h0, r}, 16'h0000);
    chk("R1", "single_phy", {15'b0, single_phy}, 16'h0);
    chk("R1", "ovr_sticky", {15'b0, ovr_sticky}, 16'h0);
    chk("R1", "rd_sop", {15'b0, rd_sop}, 16'h1);
    chk("R1", "rd_idle", {15'b0, rd_idle}, 16'h1);

    // R2 register fields and decoding
    set_cfg(8'h10);
    reg_read(8'h6A, r); chk("R2", "config single", {8'h0, r}, 16'h0010);
    chk("R2", "single_phy on", {15'b0, single_phy}, 16'h1);
    chk("R2", "handshake off", {15'b0, handshake_mode}, 16'h0);
    set_cfg(8'hFF);
    reg_read(8'h6A, r); chk("R2", "config upper masked", {8'h0, r}, 16'h003F);
    chk("R2", "handshake on", {15'b0, handshake_mode}, 16'h1);
    reg_read(8'h55, r); chk("R2", "unmapped addr", {8'h0, r}, 16'h0000);
    set_cfg(8'h20);
    chk("R2", "single_phy off", {15'b0, single_phy}, 16'h0);

    // R7 idle cells in all four layouts
    for (int m = 0; m < 4; m++) begin
      set_cfg({6'b0, 2'(m)} == 0 ? 8'h00 : {4'b0, 1'(m >> 1), 2'b00, 1'(m & 1)});
      read_idle_cell("R7");
    end

    // R9 flush versus non-flushing writes
    set_cfg(8'h02);
    write_cell(b_units());
    set_cfg(8'h12);
    reg_read(8'h71, r); chk("R9", "mode-only write keeps data", {8'h0, r}, {8'h0, b_status()});
    chk("R9", "user cell kept", {15'b0, rd_idle}, 16'h0);
    set_cfg(8'h14);
    reg_read(8'h71, r); chk("R9", "depth change flushes", {8'h0, r}, 16'h0003);
    chk("R9", "idle after flush", {15'b0, rd_idle}, 16'h1);

    // random layouts with directed fill levels
    for (int it = 0; it < 10; it++) begin
      logic [7:0] nv;
      int k, n;
      nv = {m_cfg[7:4], m_cfg[3:0] ^ 4'(1 + $urandom % 15)};
      set_cfg(nv);
      chk("R9", "ovr cleared by flush", {15'b0, ovr_sticky}, 16'h0);
      n = b_units();
      k = (it % 2 == 1) ? b_cap() : 1 + int'($urandom % b_cap());

      // R3 partial cell is not served
      for (int u = 0; u < n - 1; u++) begin
        logic [15:0] d;
        d = 16'($urandom);
        put_unit(d);
        q.push_back(m_w16 ? d : {8'h00, d[7:0]});
      end
      reg_read(8'h71, r); chk("R6", "partial not empty", {8'h0, r}, {14'h0, 2'b10});
      @(negedge clk);
      chk("R3", "partial gives idle", {15'b0, rd_idle}, 16'h1);
      begin
        logic [15:0] d;
        d = 16'($urandom);
        put_unit(d);
        q.push_back(m_w16 ? d : {8'h00, d[7:0]});
      end
      m_cells++;
      @(negedge clk);
      chk("R3", "complete gives user", {15'b0, rd_idle}, 16'h0);

      for (int c = 1; c < k; c++) begin
        write_cell(n);
        reg_read(8'h71, r); chk("R4", "fill status", {8'h0, r}, {8'h0, b_status()});
      end

      if (k == b_cap()) begin
        // R5 write while full is dropped
        reg_read(8'h71, r); chk("R4", "full flag", {8'h0, r}, 16'h0000);
        put_unit(16'hBEEF);
        put_unit(16'hCAFE);
        chk("R5", "ovr set", {15'b0, ovr_sticky}, 16'h1);
        reg_read(8'h71, r); chk("R5", "still full", {8'h0, r}, 16'h0000);
      end

      for (int c = 0; c < k; c++) read_user_cell();
      if (k == b_cap())
        chk("R5", "ovr sticky after reads", {15'b0, ovr_sticky}, 16'h1);
      reg_read(8'h71, r); chk("R6", "empty after drain", {8'h0, r}, 16'h0003);
      read_unit("R3", b_idle_unit(0), 1'b1, 1'b1);
      read_idle_cell_rest();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic read_idle_cell_rest();
    int n;
    n = b_units();
    for (int u = 1; u < n; u++) read_unit("R7", b_idle_unit(u), 1'b0, 1'b1);
  endtask
endmodule